// File: doc/BRIEF.md
# Isochronous Bus Cycle Timer

This block keeps bus time for the link layer of a serial bus that carries isochronous traffic. The 32-bit time value has three fields. The low field counts clock ticks inside one 125 µs cycle. The middle field counts cycles within one second. The top field counts seconds. The value can advance in two ways, chosen by a source select input. In internal mode, each qualified 24.576 MHz tick adds one to the low field. In external mode, each rising edge of an asynchronous 8 kHz cycle input starts a new cycle.

A node that is not the cycle master keeps in step with the bus by taking the timestamp from each received cycle-start packet. This block does not parse packets: the timestamp arrives on a parallel port together with a valid strobe. Software can read the value at any time and can overwrite it. A one-cycle strobe marks each cycle start. On the master, that is each cycle boundary the counter reaches by itself. On any other node, it is each accepted packet timestamp.

Top module: `bus_cycle_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `cur_time` is 0 and `cycle_start` is 0.
- R2: In internal mode (`src_ext`=0) with `timer_en`=1, each clock with `tick_en`=1 raises the offset field `cur_time[11:0]` by one at that edge. A clock with `tick_en`=0 leaves `cur_time` unchanged.
- R3: In internal mode, a tick at offset 3071 sets the offset to 0 and adds one to the cycle field `cur_time[24:12]`. The cycle field goes from 7999 to 0 and adds one to the seconds field `cur_time[31:25]`. The seconds field goes from 127 to 0.
- R4: In external mode (`src_ext`=1) with `timer_en`=1, `tick_en` has no effect. A rising edge on `ext_cycle_in` sets the offset to 0 and adds one to the cycle field, with the same carry as R3. The new value appears at the third rising clock edge after the input rises, because the input first passes a two-flop synchronizer and an edge detector.
- R5: With `timer_en`=0, ticks and external edges leave `cur_time` unchanged. Writes and packet loads still take effect.
- R6: With `cyc_master`=0, `pkt_valid`=1 loads `pkt_time` into `cur_time` at that clock edge, ahead of any counting. With `cyc_master`=1, `pkt_valid` is ignored and counting goes on as if no packet had arrived.
- R7: `wr_en`=1 loads `wr_data` into `cur_time` at that clock edge. It takes priority over a packet load and over counting in the same cycle.
- R8: `cycle_start` is high for exactly one cycle, in the same cycle that the new value shows on `cur_time`. It rises when a master reaches a cycle boundary by counting (an offset wrap in internal mode, or an external edge in external mode). It also rises when a non-master accepts a packet load. A register write never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Qualifier for the 24.576 MHz tick, one clock wide per tick |
| src_ext | input | 1 | Source select: 1 = external 8 kHz cycle input, 0 = internal tick |
| timer_en | input | 1 | Enables counting |
| cyc_master | input | 1 | The node is the cycle master |
| ext_cycle_in | input | 1 | Asynchronous 8 kHz cycle input |
| pkt_valid | input | 1 | A received cycle-start timestamp is valid |
| pkt_time | input | 32 | Timestamp from the received cycle-start packet |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| cur_time | output | 32 | Current timer value: {seconds, cycle, offset} |
| cycle_start | output | 1 | One-cycle cycle-start strobe |

## Verification
A wrong offset or carry shows on `cur_time` at the very next edge. A carry that is lost at offset 3071 or cycle 7999 leaves a field that does not match at the wrap, and every later value is off from then on. A fault in the synchronizer or the edge detector moves or drops the external update. The bench sees this as a change one edge early, one edge late, or missing, against the three-edge latency. A fault in the priority between write, load and counting shows within one cycle. Either the loaded value is wrong, or `cycle_start` fires when it should not, or stays low when it should fire.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
  // Which update the timer takes in the current cycle, in priority order
  typedef enum logic [2:0] {
    UPD_NONE  = 3'd0,
    UPD_WRITE = 3'd1,
    UPD_LOAD  = 3'd2,
    UPD_TICK  = 3'd3,
    UPD_EDGE  = 3'd4
  } upd_kind_e;
endpackage

// File: rtl/cyc_sync_edge.sv
module cyc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  // chain[0..STAGES-1] is the synchronizer; chain[STAGES] holds the previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= async_in;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/cyc_update_sel.sv
module cyc_update_sel
  import cyc_timer_pkg::*;
(
  input  logic      wr_en,
  input  logic      pkt_valid,
  input  logic      cyc_master,
  input  logic      timer_en,
  input  logic      src_ext,
  input  logic      tick_en,
  input  logic      ext_rise,
  output upd_kind_e upd_kind
);
  always_comb begin
    upd_kind = UPD_NONE;
    if (wr_en)                         upd_kind = UPD_WRITE;
    else if (pkt_valid && !cyc_master) upd_kind = UPD_LOAD;
    else if (timer_en) begin
      if (src_ext) begin
        if (ext_rise) upd_kind = UPD_EDGE;
      end else if (tick_en) begin
        upd_kind = UPD_TICK;
      end
    end
  end
endmodule

// File: rtl/cyc_time_core.sv
module cyc_time_core
  import cyc_timer_pkg::*;
#(
  parameter int OFF_MOD = 3072,
  parameter int CNT_MOD = 8000,
  parameter int SEC_MOD = 128,
  localparam int OFF_W  = $clog2(OFF_MOD),
  localparam int CNT_W  = $clog2(CNT_MOD),
  localparam int SEC_W  = $clog2(SEC_MOD),
  localparam int TIME_W = OFF_W + CNT_W + SEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  upd_kind_e         upd_kind,
  input  logic [TIME_W-1:0] wr_data,
  input  logic [TIME_W-1:0] pkt_time,
  output logic [TIME_W-1:0] cur_time,
  output logic              cycle_boundary
);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFF_MOD - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CNT_MOD - 1);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_MOD - 1);

  // Start a new cycle: offset cleared, cycle count raised with carry into seconds
  function automatic logic [TIME_W-1:0] f_new_cycle(input logic [TIME_W-1:0] t);
    logic [SEC_W-1:0] s;
    logic [CNT_W-1:0] c;
    s = t[TIME_W-1 -: SEC_W];
    c = t[OFF_W +: CNT_W];
    if (c >= CNT_LAST) begin
      c = '0;
      s = (s >= SEC_LAST) ? '0 : s + SEC_W'(1);
    end else begin
      c = c + CNT_W'(1);
    end
    return {s, c, {OFF_W{1'b0}}};
  endfunction

  function automatic logic f_offset_last(input logic [TIME_W-1:0] t);
    return t[OFF_W-1:0] >= OFF_LAST;
  endfunction

  // One internal tick: offset +1, or a new cycle at the wrap point
  function automatic logic [TIME_W-1:0] f_tick(input logic [TIME_W-1:0] t);
    if (f_offset_last(t)) return f_new_cycle(t);
    return {t[TIME_W-1:OFF_W], t[OFF_W-1:0] + OFF_W'(1)};
  endfunction

  logic [TIME_W-1:0] time_q;
  logic [TIME_W-1:0] time_d;

  always_comb begin
    case (upd_kind)
      UPD_WRITE: time_d = wr_data;
      UPD_LOAD:  time_d = pkt_time;
      UPD_TICK:  time_d = f_tick(time_q);
      UPD_EDGE:  time_d = f_new_cycle(time_q);
      default:   time_d = time_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_d;
  end

  assign cur_time       = time_q;
  assign cycle_boundary = (upd_kind == UPD_EDGE) ||
                          ((upd_kind == UPD_TICK) && f_offset_last(time_q));
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
  import cyc_timer_pkg::*;
#(
  parameter int OFF_MOD     = 3072,
  parameter int CNT_MOD     = 8000,
  parameter int SEC_MOD     = 128,
  parameter int SYNC_STAGES = 2,
  localparam int TIME_W = $clog2(OFF_MOD) + $clog2(CNT_MOD) + $clog2(SEC_MOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              src_ext,
  input  logic              timer_en,
  input  logic              cyc_master,
  input  logic              ext_cycle_in,
  input  logic              pkt_valid,
  input  logic [TIME_W-1:0] pkt_time,
  input  logic              wr_en,
  input  logic [TIME_W-1:0] wr_data,
  output logic [TIME_W-1:0] cur_time,
  output logic              cycle_start
);
  logic      ext_rise;
  upd_kind_e upd_kind;
  logic      cycle_boundary;
  logic      start_q;

  cyc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_cycle_in),
    .rise     (ext_rise)
  );

  cyc_update_sel u_sel (
    .wr_en      (wr_en),
    .pkt_valid  (pkt_valid),
    .cyc_master (cyc_master),
    .timer_en   (timer_en),
    .src_ext    (src_ext),
    .tick_en    (tick_en),
    .ext_rise   (ext_rise),
    .upd_kind   (upd_kind)
  );

  cyc_time_core #(
    .OFF_MOD (OFF_MOD),
    .CNT_MOD (CNT_MOD),
    .SEC_MOD (SEC_MOD)
  ) u_core (
    .clk            (clk),
    .rst_n          (rst_n),
    .upd_kind       (upd_kind),
    .wr_data        (wr_data),
    .pkt_time       (pkt_time),
    .cur_time       (cur_time),
    .cycle_boundary (cycle_boundary)
  );

  // Strobe is registered, so it lines up with the updated time value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= (cyc_master && cycle_boundary) || (upd_kind == UPD_LOAD);
  end

  assign cycle_start = start_q;
endmodule

// File: rtl/cyc_timer_chk.sv
module cyc_timer_chk
  import cyc_timer_pkg::*;
#(
  parameter int OFF_MOD = 3072,
  parameter int TIME_W  = 32,
  localparam int OFF_W  = $clog2(OFF_MOD)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TIME_W-1:0] cur_time,
  input logic              cycle_start,
  input logic              wr_en,
  input logic [TIME_W-1:0] wr_data,
  input logic              pkt_valid,
  input logic [TIME_W-1:0] pkt_time,
  input logic              cyc_master,
  input logic              timer_en,
  input upd_kind_e         upd_kind
);
  logic [OFF_W-1:0] off;
  assign off = cur_time[OFF_W-1:0];

  // R2
  p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_kind == UPD_TICK && off != OFF_W'(OFF_MOD - 1)) |=>
      (off == $past(off) + OFF_W'(1)) &&
      (cur_time[TIME_W-1:OFF_W] == $past(cur_time[TIME_W-1:OFF_W])));

  // R3
  p_offset_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_kind == UPD_TICK && off == OFF_W'(OFF_MOD - 1)) |=> (off == '0));

  // R4
  p_edge_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_kind == UPD_EDGE) |=> (off == '0));

  // R5
  p_hold_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!timer_en && !wr_en && !(pkt_valid && !cyc_master)) |=> $stable(cur_time));

  // R6
  p_pkt_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !cyc_master && !wr_en) |=> (cur_time == $past(pkt_time)));

  // R7
  p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cur_time == $past(wr_data)));

  // R8
  p_no_start_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !cycle_start);

  p_master_start_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_master && !wr_en) ##1 cycle_start |-> (off == '0));
endmodule

bind bus_cycle_timer cyc_timer_chk #(
  .OFF_MOD (OFF_MOD),
  .TIME_W  (TIME_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cur_time    (cur_time),
  .cycle_start (cycle_start),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .pkt_valid   (pkt_valid),
  .pkt_time    (pkt_time),
  .cyc_master  (cyc_master),
  .timer_en    (timer_en),
  .upd_kind    (upd_kind)
);

// File: tb/bus_cycle_timer_tb_top.sv
module bus_cycle_timer_tb_top;
  localparam longint OFFS   = 3072;
  localparam longint CYCS   = 8000;
  localparam longint SECS   = 128;
  localparam longint PERSEC = OFFS * CYCS;
  localparam longint TOTAL  = PERSEC * SECS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, src_ext = 1'b0, timer_en = 1'b0, cyc_master = 1'b0;
  logic        ext_cycle_in = 1'b0, pkt_valid = 1'b0, wr_en = 1'b0;
  logic [31:0] pkt_time = '0, wr_data = '0;
  logic [31:0] cur_time;
  logic        cycle_start;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_cycle_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .src_ext(src_ext),
    .timer_en(timer_en), .cyc_master(cyc_master), .ext_cycle_in(ext_cycle_in),
    .pkt_valid(pkt_valid), .pkt_time(pkt_time), .wr_en(wr_en), .wr_data(wr_data),
    .cur_time(cur_time), .cycle_start(cycle_start)
  );

  // Bench model: time is held as one linear tick count, not as three fields
  longint mdl_t = 0;
  logic   h1 = 1'b0, h2 = 1'b0, h3 = 1'b0;   // past values of ext_cycle_in at each step

  logic [31:0] q_time[$];
  logic        q_start[$];
  string       q_tag[$];

  function automatic logic [31:0] fld(input longint s, input longint c, input longint o);
    logic [6:0]  sv = s[6:0];
    logic [12:0] cv = c[12:0];
    logic [11:0] ov = o[11:0];
    return {sv, cv, ov};
  endfunction

  function automatic longint to_lin(input logic [31:0] v);
    return (longint'(v[31:25]) * CYCS + longint'(v[24:12])) * OFFS + longint'(v[11:0]);
  endfunction

  function automatic logic [31:0] from_lin(input longint t);
    return fld(t / PERSEC, (t / OFFS) % CYCS, t % OFFS);
  endfunction

  task automatic step(input logic te, input logic pv, input logic [31:0] pt,
                      input logic we, input logic [31:0] wd, input string tag);
    logic rise;
    logic stb;
    @(negedge clk);
    tick_en = te; pkt_valid = pv; pkt_time = pt; wr_en = we; wr_data = wd;
    rise = h2 & ~h3;
    h3 = h2; h2 = h1; h1 = ext_cycle_in;
    stb = 1'b0;
    if (we) mdl_t = to_lin(wd);
    else if (pv && !cyc_master) begin
      mdl_t = to_lin(pt);
      stb = 1'b1;
    end else if (timer_en) begin
      if (src_ext) begin
        if (rise) begin
          mdl_t = ((mdl_t / OFFS + 1) % (CYCS * SECS)) * OFFS;
          stb = cyc_master;
        end
      end else if (te) begin
        if (mdl_t % OFFS == OFFS - 1) stb = cyc_master;
        mdl_t = (mdl_t + 1) % TOTAL;
      end
    end
    @(posedge clk);
    #1;
    q_time.push_back(from_lin(mdl_t));
    q_start.push_back(stb);
    q_tag.push_back(tag);
  endtask

  task automatic ticks(input int n, input logic te, input string tag);
    for (int i = 0; i < n; i++) step(te, 1'b0, '0, 1'b0, '0, tag);
  endtask

  // Monitor: pops the expected item for each edge and compares
  always @(posedge clk) begin
    #2;
    while (q_time.size() > 0) begin
      logic [31:0] et;
      logic        es;
      string       tg;
      et = q_time.pop_front();
      es = q_start.pop_front();
      tg = q_tag.pop_front();
      checks++;
      if (cur_time !== et || cycle_start !== es) begin
        errors++;
        $display("FAIL %s: cur_time=%h cycle_start=%b expected %h %b", tg, cur_time, cycle_start, et, es);
      end
    end
  end

  task automatic direct_check(input string tag, input logic [31:0] et, input logic es);
    checks++;
    if (cur_time !== et || cycle_start !== es) begin
      errors++;
      $display("FAIL %s: cur_time=%h cycle_start=%b expected %h %b", tag, cur_time, cycle_start, et, es);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    direct_check("R1 in reset", 32'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    direct_check("R1 after release", 32'h0, 1'b0);

    // R2: internal ticks, with and without the qualifier
    timer_en = 1'b1; src_ext = 1'b0; cyc_master = 1'b0;
    ticks(5, 1'b1, "R2 ticking");
    ticks(3, 1'b0, "R2 no tick");
    for (int i = 0; i < 6; i++) step(logic'(i % 2), 1'b0, '0, 1'b0, '0, "R2 sparse ticks");

    // R3 and R8: wraps as master
    cyc_master = 1'b1;
    step(1'b0, 1'b0, '0, 1'b1, fld(5, 10, 3069), "R7 write");
    ticks(4, 1'b1, "R3 offset wrap R8");
    step(1'b0, 1'b0, '0, 1'b1, fld(4, 7999, 3070), "R7 write");
    ticks(3, 1'b1, "R3 cycle wrap R8");
    step(1'b0, 1'b0, '0, 1'b1, fld(127, 7999, 3070), "R7 write");
    ticks(3, 1'b1, "R3 seconds wrap R8");
    step(1'b1, 1'b0, '0, 1'b1, fld(9, 9, 3071), "R7 write over tick R8");

    // R5: disabled
    timer_en = 1'b0;
    ticks(4, 1'b1, "R5 hold");
    step(1'b1, 1'b0, '0, 1'b1, fld(1, 2, 3), "R5 write while off");
    ticks(2, 1'b1, "R5 hold");
    cyc_master = 1'b0;
    step(1'b1, 1'b1, fld(3, 4, 5), 1'b0, '0, "R5 load while off R6");
    ticks(2, 1'b1, "R5 hold");

    // R6: packet loads
    timer_en = 1'b1;
    step(1'b1, 1'b1, fld(20, 300, 3071), 1'b0, '0, "R6 load beats tick");
    ticks(2, 1'b1, "R6 after load");
    cyc_master = 1'b1;
    step(1'b1, 1'b1, fld(1, 1, 1), 1'b0, '0, "R6 master ignores");
    step(1'b0, 1'b1, fld(2, 2, 2), 1'b0, '0, "R6 master ignores");
    cyc_master = 1'b0;
    step(1'b1, 1'b1, fld(7, 7, 7), 1'b1, fld(8, 8, 8), "R7 write beats load");
    ticks(2, 1'b1, "R2 after write");

    // R4: external source, as master
    src_ext = 1'b1; cyc_master = 1'b1;
    step(1'b0, 1'b0, '0, 1'b1, fld(2, 7998, 100), "R7 write");
    for (int p = 0; p < 4; p++) begin
      ext_cycle_in = 1'b1;
      ticks(4, 1'b1, "R4 external edge R8");
      ext_cycle_in = 1'b0;
      ticks(3, 1'b1, "R4 external low");
    end
    // R4 non-master: edge counts with no strobe
    cyc_master = 1'b0;
    ext_cycle_in = 1'b1;
    ticks(4, 1'b1, "R4 non-master edge");
    ext_cycle_in = 1'b0;
    ticks(3, 1'b1, "R4 non-master low");
    // R5: edge while disabled
    timer_en = 1'b0;
    ext_cycle_in = 1'b1;
    ticks(4, 1'b1, "R5 edge while off");
    ext_cycle_in = 1'b0;
    ticks(3, 1'b0, "R5 edge while off");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule